// File: doc/BRIEF.md
# Register-Format Integer ALU

This block is the arithmetic and logic stage for three-register instructions in a small 32-bit processor core. It takes two operand words read from the register file and the 6-bit function field of the instruction, and returns the result word in the same cycle. There is no internal state. The surrounding pipeline registers the result and uses the zero flag. The function map is nonstandard. Multiply and divide are ordinary single-result operations. Both shift instructions take their count from the second operand register, not from an instruction field.

The function field is decoded into one internal operation code. Each datapath unit computes its answer in parallel: adder, subtractor, multiplier, divider, two shifters, the logic operations and the signed comparator. A selector then forwards the one chosen by the decoded code. A function code that is not in the map produces a zero result and raises an invalid-function flag. The core can use that flag to raise a reserved-instruction exception.

There is no state register, so the house style's state list does not apply. The only "states" are the ten decoded operation codes: add, subtract, multiply, divide, and, or, set-less-than, shift-left, shift-right and invalid. The only "transition" is a change of the function input, which re-selects the code in the same evaluation.

Top module: `alu_core`

## Requirements
- R1: Function code 100000 (0x20) gives the 32-bit wrapping sum opa + opb.
- R2: Function code 100010 (0x22) gives the 32-bit wrapping difference opa - opb.
- R3: Function code 100100 (0x24) gives the low 32 bits of the signed product of opa and opb.
- R4: Function code 100101 (0x25) gives the signed quotient opa / opb, truncated toward zero. The case -2^31 / -1 returns 0x80000000.
- R5: Under function code 100101, a divisor of zero returns 0xFFFFFFFF, and invalid stays 0.
- R6: Function code 101000 (0x28) gives bitwise AND, and 101001 (0x29) gives bitwise OR.
- R7: Function code 110100 (0x34) gives 1 when opa < opb as signed two's-complement values, otherwise 0.
- R8: Function code 111000 (0x38) shifts opa toward the most significant end by opb[4:0], filling with zeros. Bits opb[31:5] are ignored.
- R9: Function code 111001 (0x39) shifts opa toward the least significant end by opb[4:0], filling with zeros. Bits opb[31:5] are ignored.
- R10: zero is 1 exactly when result equals 0, for every function code.
- R11: Any function code other than the nine above gives result 0, invalid 1 and zero 1. Every listed code gives invalid 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa | input | 32 | First source operand |
| opb | input | 32 | Second source operand; its low 5 bits are the shift count |
| funct | input | 6 | Function field selecting the operation |
| result | output | 32 | Selected operation result |
| zero | output | 1 | High when result is all zeros |
| invalid | output | 1 | High when funct is not a listed code |

## Verification
Two functions can coincide in one evaluation, and the bench provokes both pairings. The first is the invalid-function path together with the zero flag: an unlisted code must force a zero result, so both flags rise at once. The second is division by zero together with that same flag logic: the all-ones quotient must keep zero low and must not raise invalid, even though the divisor is zero. The bench sweeps all 64 function codes with non-zero operands and judges each against a behavioural model. It then applies directed divide-by-zero, overflowing-divide, set-less-than-false and equal-operand subtraction vectors, and samples result, zero and invalid together at the falling clock edge.

// File: rtl/alu_pkg.sv
package alu_pkg;

    localparam int FUNCT_W = 6;

    localparam logic [FUNCT_W-1:0] FN_ADD = 6'b100000;
    localparam logic [FUNCT_W-1:0] FN_SUB = 6'b100010;
    localparam logic [FUNCT_W-1:0] FN_MUL = 6'b100100;
    localparam logic [FUNCT_W-1:0] FN_DIV = 6'b100101;
    localparam logic [FUNCT_W-1:0] FN_AND = 6'b101000;
    localparam logic [FUNCT_W-1:0] FN_OR  = 6'b101001;
    localparam logic [FUNCT_W-1:0] FN_SLT = 6'b110100;
    localparam logic [FUNCT_W-1:0] FN_SLL = 6'b111000;
    localparam logic [FUNCT_W-1:0] FN_SRL = 6'b111001;

    typedef enum logic [3:0] {
        OP_ADD,
        OP_SUB,
        OP_MUL,
        OP_DIV,
        OP_AND,
        OP_OR,
        OP_SLT,
        OP_SLL,
        OP_SRL,
        OP_BAD
    } alu_op_e;

endpackage

// File: rtl/alu_funct_decode.sv
module alu_funct_decode
    import alu_pkg::*;
(
    input  logic [FUNCT_W-1:0] funct,
    output alu_op_e            op
);

    always_comb begin
        unique case (funct)
            FN_ADD:  op = OP_ADD;
            FN_SUB:  op = OP_SUB;
            FN_MUL:  op = OP_MUL;
            FN_DIV:  op = OP_DIV;
            FN_AND:  op = OP_AND;
            FN_OR:   op = OP_OR;
            FN_SLT:  op = OP_SLT;
            FN_SLL:  op = OP_SLL;
            FN_SRL:  op = OP_SRL;
            default: op = OP_BAD;
        endcase
    end

endmodule

// File: rtl/alu_barrel.sv
// Logarithmic shifter; TO_MSB picks the direction, zeros fill vacated bits.
module alu_barrel #(
    parameter int W      = 32,
    parameter bit TO_MSB = 1'b1
) (
    input  logic [W-1:0]         din,
    input  logic [$clog2(W)-1:0] amt,
    output logic [W-1:0]         dout
);

    localparam int SW = $clog2(W);

    logic [W-1:0] stage [0:SW];

    assign stage[0] = din;

    for (genvar i = 0; i < SW; i++) begin : g_stage
        if (TO_MSB) begin : g_left
            assign stage[i+1] = amt[i] ? (stage[i] << (1 << i)) : stage[i];
        end else begin : g_right
            assign stage[i+1] = amt[i] ? (stage[i] >> (1 << i)) : stage[i];
        end
    end

    assign dout = stage[SW];

endmodule

// File: rtl/alu_sdiv.sv
// Signed divide via magnitudes; zero divisor yields all ones.
module alu_sdiv #(
    parameter int W = 32
) (
    input  logic [W-1:0] num,
    input  logic [W-1:0] den,
    output logic [W-1:0] quo
);

    logic [W-1:0] mag_n;
    logic [W-1:0] mag_d;
    logic [W-1:0] mag_q;
    logic         neg_q;
    logic         den_zero;

    assign mag_n    = num[W-1] ? (~num + 1'b1) : num;
    assign mag_d    = den[W-1] ? (~den + 1'b1) : den;
    assign neg_q    = num[W-1] ^ den[W-1];
    assign den_zero = (den == '0);
    assign mag_q    = den_zero ? '0 : (mag_n / mag_d);

    always_comb begin
        if (den_zero) begin
            quo = '1;
        end else if (neg_q) begin
            quo = ~mag_q + 1'b1;
        end else begin
            quo = mag_q;
        end
    end

endmodule

// File: rtl/alu_core.sv
module alu_core
    import alu_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0]       opa,
    input  logic [W-1:0]       opb,
    input  logic [FUNCT_W-1:0] funct,
    output logic [W-1:0]       result,
    output logic               zero,
    output logic               invalid
);

    localparam int SW = $clog2(W);

    alu_op_e      op;
    logic [W-1:0] sum_w;
    logic [W-1:0] diff_w;
    logic [W-1:0] prod_w;
    logic [W-1:0] quo_w;
    logic [W-1:0] shl_w;
    logic [W-1:0] shr_w;
    logic         lt_w;

    alu_funct_decode u_dec (
        .funct (funct),
        .op    (op)
    );

    alu_barrel #(.W(W), .TO_MSB(1'b1)) u_shl (
        .din  (opa),
        .amt  (opb[SW-1:0]),
        .dout (shl_w)
    );

    alu_barrel #(.W(W), .TO_MSB(1'b0)) u_shr (
        .din  (opa),
        .amt  (opb[SW-1:0]),
        .dout (shr_w)
    );

    alu_sdiv #(.W(W)) u_div (
        .num (opa),
        .den (opb),
        .quo (quo_w)
    );

    assign sum_w  = opa + opb;
    assign diff_w = opa - opb;
    assign prod_w = W'($signed(opa) * $signed(opb));
    assign lt_w   = ($signed(opa) < $signed(opb));

    always_comb begin
        invalid = 1'b0;
        unique case (op)
            OP_ADD:  result = sum_w;
            OP_SUB:  result = diff_w;
            OP_MUL:  result = prod_w;
            OP_DIV:  result = quo_w;
            OP_AND:  result = opa & opb;
            OP_OR:   result = opa | opb;
            OP_SLT:  result = {{(W-1){1'b0}}, lt_w};
            OP_SLL:  result = shl_w;
            OP_SRL:  result = shr_w;
            default: begin
                result  = '0;
                invalid = 1'b1;
            end
        endcase
    end

    assign zero = ~|result;

    // Immediate checks, skipped while any input is still unknown.
    always_comb begin
        if (!$isunknown({opa, opb, funct})) begin
            if (invalid) begin
                a_r11_invalid_clears: assert (result == '0 && zero)
                    else $error("R11: invalid code left non-zero result");
            end
            if (funct == FN_DIV && opb == '0) begin
                a_r5_div_zero_ones: assert (result == '1 && !invalid && !zero)
                    else $error("R5: zero divisor did not give all ones");
            end
            if (funct == FN_SLT) begin
                a_r7_slt_boolean: assert (result[W-1:1] == '0 && !invalid)
                    else $error("R7: compare result not boolean");
            end
            if (funct == FN_SLL && opb[SW-1:0] == '0) begin
                a_r8_zero_count_passes: assert (result == opa)
                    else $error("R8: zero shift count altered operand");
            end
            if (funct == FN_SRL && opb[SW-1:0] != '0) begin
                a_r9_msb_filled_zero: assert (!result[W-1])
                    else $error("R9: right shift did not fill with zero");
            end
        end
    end

endmodule

// File: tb/sim_alu_core.sv
module sim_alu_core;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] opa = '0;
    logic [31:0] opb = '0;
    logic [5:0]  funct = '0;
    logic [31:0] result;
    logic        zero;
    logic        invalid;

    int n_chk  = 0;
    int n_fail = 0;
    int cycles = 0;

    always #10 clk = ~clk;

    alu_core u0 (
        .opa     (opa),
        .opb     (opb),
        .funct   (funct),
        .result  (result),
        .zero    (zero),
        .invalid (invalid)
    );

    localparam int NV = 16;
    localparam logic [31:0] TA [NV] = '{
        32'h0000_0007, 32'hFFFF_FFF9, 32'h7FFF_FFFF, 32'h8000_0000,
        32'h1234_5678, 32'hDEAD_BEEF, 32'h0000_0064, 32'hFFFF_FF9C,
        32'h0000_0001, 32'hF0F0_F0F0, 32'h0001_0000, 32'h0000_0000,
        32'hFFFF_FFFF, 32'h8000_0001, 32'h0000_0005, 32'h4000_0000
    };
    localparam logic [31:0] TB [NV] = '{
        32'h0000_0002, 32'h0000_0002, 32'h0000_0001, 32'hFFFF_FFFF,
        32'h0000_0004, 32'h0000_0010, 32'hFFFF_FFF9, 32'h0000_0007,
        32'h0000_001F, 32'h0F0F_0F0F, 32'h0001_0000, 32'h0000_0000,
        32'h0000_0021, 32'h8000_0000, 32'h0000_0005, 32'h0000_0003
    };
    localparam logic [5:0] TF [NV] = '{
        6'h25, 6'h25, 6'h20, 6'h25,
        6'h38, 6'h39, 6'h25, 6'h24,
        6'h38, 6'h28, 6'h24, 6'h29,
        6'h39, 6'h34, 6'h22, 6'h24
    };

    function automatic logic [32:0] model(input logic [31:0] a, input logic [31:0] b,
                                          input logic [5:0] f);
        longint      la;
        longint      lb;
        longint      lr;
        logic [31:0] r;
        logic        bad;
        la  = longint'($signed(a));
        lb  = longint'($signed(b));
        bad = 1'b0;
        r   = '0;
        case (f)
            6'h20: r = a + b;
            6'h22: r = a - b;
            6'h24: begin lr = la * lb; r = lr[31:0]; end
            6'h25: begin
                if (b == 0) r = 32'hFFFF_FFFF;
                else begin lr = la / lb; r = lr[31:0]; end
            end
            6'h28: r = a & b;
            6'h29: r = a | b;
            6'h34: r = (la < lb) ? 32'd1 : 32'd0;
            6'h38: r = a << b[4:0];
            6'h39: r = a >> b[4:0];
            default: bad = 1'b1;
        endcase
        return {bad, r};
    endfunction

    function automatic string req_of(input logic [5:0] f);
        case (f)
            6'h20: return "R1";
            6'h22: return "R2";
            6'h24: return "R3";
            6'h25: return "R4";
            6'h28: return "R6";
            6'h29: return "R6";
            6'h34: return "R7";
            6'h38: return "R8";
            6'h39: return "R9";
            default: return "R11";
        endcase
    endfunction

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h (a=%h b=%h f=%h)",
                     req, got, exp, opa, opb, funct);
        end
    endtask

    task automatic apply(input logic [31:0] a, input logic [31:0] b, input logic [5:0] f);
        @(posedge clk);
        #1;
        opa   = a;
        opb   = b;
        funct = f;
        @(negedge clk);
    endtask

    // Checks result against the model plus both flags (R10, R11).
    task automatic check_all(input string req);
        logic [32:0] m;
        m = model(opa, opb, funct);
        check(req, result, m[31:0]);
        check("R10", {31'd0, zero}, {31'd0, (m[31:0] == 0)});
        check("R11", {31'd0, invalid}, {31'd0, m[32]});
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected under 20000", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        // Reset-time state: zero inputs, funct 000000 is unlisted (R11).
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R11", result, 32'h0);
        check("R11", {31'd0, invalid}, 32'd1);
        check("R10", {31'd0, zero}, 32'd1);
        rst = 1'b0;

        // Vector table.
        for (int i = 0; i < NV; i++) begin
            apply(TA[i], TB[i], TF[i]);
            check_all(req_of(TF[i]));
        end

        // Every function code with non-zero operands.
        for (int f = 0; f < 64; f++) begin
            apply(32'hC3A5_0F96, 32'h0000_0123, 6'(f));
            check_all(req_of(6'(f)));
        end

        // Directed corners.
        apply(32'h0000_1234, 32'h0, 6'h25);          // R5 zero divisor
        check("R5", result, 32'hFFFF_FFFF);
        check("R5", {30'd0, zero, invalid}, 32'd0);
        apply(32'h8000_0000, 32'hFFFF_FFFF, 6'h25);  // R4 overflow case
        check("R4", result, 32'h8000_0000);
        apply(32'hFFFF_FFF9, 32'h0000_0002, 6'h25);  // R4 -7/2 = -3
        check("R4", result, 32'hFFFF_FFFD);
        apply(32'h0000_0007, 32'hFFFF_FFFE, 6'h25);  // R4 7/-2 = -3
        check("R4", result, 32'hFFFF_FFFD);
        apply(32'h0000_0001, 32'hFFFF_FFE3, 6'h38);  // R8 count uses low 5 bits = 3
        check("R8", result, 32'h0000_0008);
        apply(32'h8000_0000, 32'h0000_0020, 6'h39);  // R9 count 32 -> 0
        check("R9", result, 32'h8000_0000);
        apply(32'h8000_0000, 32'h0000_003F, 6'h39);  // R9 zero fill
        check("R9", result, 32'h0000_0001);
        apply(32'hFFFF_FFFF, 32'h0000_0001, 6'h34);  // R7 -1 < 1 signed
        check("R7", result, 32'h1);
        apply(32'h0000_0001, 32'hFFFF_FFFF, 6'h34);  // R7 1 < -1 false
        check("R7", result, 32'h0);
        check("R10", {31'd0, zero}, 32'd1);
        apply(32'h0000_0042, 32'h0000_0042, 6'h22);  // R2 equal operands
        check("R2", result, 32'h0);
        check("R10", {31'd0, zero}, 32'd1);
        apply(32'hFFFF_FFFF, 32'h0000_0001, 6'h20);  // R1 wrap to zero
        check("R1", result, 32'h0);
        check("R10", {31'd0, zero}, 32'd1);
        apply(32'h0001_0001, 32'h0001_0001, 6'h24);  // R3 low bits of product
        check("R3", result, 32'h0002_0001);
        apply(32'hFFFF_0000, 32'h0000_FFFF, 6'h28);  // R6 disjoint and
        check("R6", result, 32'h0);
        apply(32'hFFFF_FFFF, 32'hFFFF_FFFF, 6'h3F);  // R11 unlisted
        check("R11", result, 32'h0);
        check("R11", {30'd0, zero, invalid}, 32'd3);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule